// File: doc/BRIEF.md
# Conversion Engine Sequencer

This block sits between a processor's byte-wide register bus and a shared successive-approximation converter. Software asks for a conversion by setting one of three engine bits (auxiliary, battery, touch). The block feeds the converter one request at a time and waits for its 12-bit answer. It keeps the auxiliary and battery answers in result registers, clears the engine bit when the answer arrives, and records completion in a status register that drives a level interrupt.

Toward the converter, the request side is a valid/ready pair carrying a source code and a reference-range flag. The block raises `conv_req_valid` and holds the source and range stable until the converter takes the request with `conv_req_ready`. There is one exception: if software clears the engine bit first, the request is withdrawn. The result side is also valid/ready. `conv_res_ready` is high only while a conversion is outstanding, and the converter must hold `conv_res_valid` and `conv_res_data` until it sees ready. A result whose engine was aborted in the meantime is still taken, then thrown away.

A power-down bit blocks all conversion activity. Four event inputs from the touch front end are logged in the same status register.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, config 0x00, mask 0xFF, status 0x00 and all result bytes 0x00. `irq`, `conv_req_valid` and `conv_res_ready` are low.
- R2: Writing address 0 with bit 0 (aux), bit 1 (battery) or bit 2 (touch) set starts that engine. The bit reads back as 1 until the result is accepted, and then as 0 from the next cycle on.
- R3: At most one conversion is in progress, and pending engines are served in the order aux, battery, touch. While `conv_req_valid` waits for ready, `conv_src` is held unless the bus writes.
- R4: `conv_src` is 0 for the first aux input, 1 for the second aux input (selected when config bits [1:0] equal 2), 2 for battery and 3 for touch. `conv_lowref` equals config bit 4 for a battery request and is 0 otherwise.
- R5: The aux result reads at address 4 (bits 7:0) and 5 (bits 11:8, upper nibble zero), and the battery result at 6 and 7. A result register changes only when its own engine completes.
- R6: Writing 0 to a pending engine bit withdraws its request. A result that arrives for an aborted engine is accepted but sets no status and leaves the result registers unchanged.
- R7: The status register at address 3 sets bit 0, 1 or 2 when the matching engine completes. It sets bits 3, 4, 5 and 7 on `evt_pulse[0..3]`. Bit 6 always reads 0.
- R8: Writing 1 to a status bit clears it. A set arriving in the same cycle as the clear wins.
- R9: `irq` is high whenever some status bit is set whose bit in the mask register (address 2) is 0.
- R10: Writing address 0 with bit 7 set enters power-down. Engine bits are cleared and cannot be set, no request is raised, and a conversion in flight is discarded. The enable register reads bit 7 as the power-down state.
- R11: A read strobe loads `bus_rdata` with the addressed register on the next clock edge, and `bus_rdata` holds that value until the next read strobe. Config (address 1) reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| evt_pulse | input | 4 | Touch front-end event pulses (pen down, pen up, pen down in sleep, sleep) |
| conv_req_valid | output | 1 | Conversion request valid |
| conv_req_ready | input | 1 | Converter accepts request |
| conv_src | output | 2 | Input source code of the request |
| conv_lowref | output | 1 | Low reference range for battery |
| conv_res_valid | input | 1 | Converter result valid |
| conv_res_ready | output | 1 | Block accepts result |
| conv_res_data | input | 12 | Converter result |
| irq | output | 1 | Level interrupt |

## Verification
A wrong arbiter state appears at the converter pins within one cycle. Either request valid and result ready are both high, or the request carries a source that does not match the highest pending engine. A wrong enable or status bit shows up on `irq` in the cycle after the event that went wrong, and on the next read of that register. A dropped abort only comes to light when the stale answer comes back, at the converter's latency. It is then seen as a status bit that should not be set, or a result byte that changed.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int ENG_N  = 3;
  localparam int EVT_N  = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } arb_st_t;

  typedef enum logic [1:0] {
    SRC_AUX_A = 2'd0,
    SRC_AUX_B = 2'd1,
    SRC_BAT   = 2'd2,
    SRC_TCH   = 2'd3
  } src_t;

  localparam logic [3:0] A_ENA  = 4'd0;
  localparam logic [3:0] A_CFG  = 4'd1;
  localparam logic [3:0] A_MASK = 4'd2;
  localparam logic [3:0] A_STAT = 4'd3;
  localparam logic [3:0] A_AUXL = 4'd4;
  localparam logic [3:0] A_AUXH = 4'd5;
  localparam logic [3:0] A_BATL = 4'd6;
  localparam logic [3:0] A_BATH = 4'd7;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [EVT_N-1:0]  evt_pulse,
  input  logic [ENG_N-1:0]  done_vec,
  input  logic [RES_W-1:0]  res_data,
  output logic [ENG_N-1:0]  en_q,
  output logic              pd_q,
  output logic              aux_b,
  output logic              low_ref,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              irq
);
  localparam int N_RES = 2;
  localparam int WIDE  = 2 * DATA_W;

  logic [DATA_W-1:0] cfg_q;
  logic [DATA_W-1:0] stat_set, stat_clr, stat_n, rd_mux;
  logic [RES_W-1:0]  res_q [N_RES];
  logic [WIDE-1:0]   res_wide [N_RES];
  logic              hit_ena, hit_cfg, hit_mask, hit_stat;

  assign hit_ena  = bus_wr && (bus_addr == ADDR_W'(A_ENA));
  assign hit_cfg  = bus_wr && (bus_addr == ADDR_W'(A_CFG));
  assign hit_mask = bus_wr && (bus_addr == ADDR_W'(A_MASK));
  assign hit_stat = bus_wr && (bus_addr == ADDR_W'(A_STAT));

  always_comb begin
    stat_set = '0;
    stat_set[ENG_N-1:0] = done_vec;
    stat_set[3] = evt_pulse[0];
    stat_set[4] = evt_pulse[1];
    stat_set[5] = evt_pulse[2];
    stat_set[7] = evt_pulse[3];
    stat_clr = hit_stat ? bus_wdata : '0;
    stat_n   = (stat_q & ~stat_clr) | stat_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pd_q   <= 1'b0;
      cfg_q  <= '0;
      mask_q <= '1;
      stat_q <= '0;
    end else begin
      if (hit_ena) begin
        pd_q <= bus_wdata[DATA_W-1];
        en_q <= bus_wdata[DATA_W-1] ? '0 : bus_wdata[ENG_N-1:0];
      end else begin
        en_q <= en_q & ~done_vec;
      end
      if (hit_cfg)  cfg_q  <= bus_wdata;
      if (hit_mask) mask_q <= bus_wdata;
      stat_q <= stat_n;
    end
  end

  for (genvar g = 0; g < N_RES; g++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          res_q[g] <= '0;
      else if (done_vec[g]) res_q[g] <= res_data;
    end
    assign res_wide[g] = WIDE'(res_q[g]);
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(A_ENA):  rd_mux = {pd_q, {(DATA_W-1-ENG_N){1'b0}}, en_q};
      ADDR_W'(A_CFG):  rd_mux = cfg_q;
      ADDR_W'(A_MASK): rd_mux = mask_q;
      ADDR_W'(A_STAT): rd_mux = stat_q;
      ADDR_W'(A_AUXL): rd_mux = res_wide[0][DATA_W-1:0];
      ADDR_W'(A_AUXH): rd_mux = res_wide[0][WIDE-1:DATA_W];
      ADDR_W'(A_BATL): rd_mux = res_wide[1][DATA_W-1:0];
      ADDR_W'(A_BATH): rd_mux = res_wide[1][WIDE-1:DATA_W];
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign aux_b   = (cfg_q[1:0] == 2'b10);
  assign low_ref = cfg_q[4];
  assign irq     = |(stat_q & ~mask_q);
endmodule

// File: rtl/adc_seq_arb.sv
module adc_seq_arb
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ENG_N-1:0] en_q,
  input  logic             aux_b,
  input  logic             low_ref,
  output logic             conv_req_valid,
  input  logic             conv_req_ready,
  output logic [1:0]       conv_src,
  output logic             conv_lowref,
  input  logic             conv_res_valid,
  output logic             conv_res_ready,
  output logic [ENG_N-1:0] done_vec
);
  localparam int IDX_W = $clog2(ENG_N);

  arb_st_t           st_q;
  logic [IDX_W-1:0]  cur_q, pick;
  logic              cur_live;

  always_comb begin
    pick = '0;
    for (int i = ENG_N - 1; i >= 0; i--) begin
      if (en_q[i]) pick = IDX_W'(i);
    end
  end

  assign cur_live       = en_q[cur_q];
  assign conv_req_valid = (st_q == ST_REQ) && cur_live;
  assign conv_res_ready = (st_q == ST_WAIT);

  always_comb begin
    done_vec = '0;
    if ((st_q == ST_WAIT) && conv_res_valid && cur_live) done_vec[cur_q] = 1'b1;
  end

  always_comb begin
    case (cur_q)
      IDX_W'(0): conv_src = aux_b ? SRC_AUX_B : SRC_AUX_A;
      IDX_W'(1): conv_src = SRC_BAT;
      default:   conv_src = SRC_TCH;
    endcase
    conv_lowref = (cur_q == IDX_W'(1)) && low_ref;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (|en_q) begin
          cur_q <= pick;
          st_q  <= ST_REQ;
        end
        ST_REQ: begin
          if (!cur_live)           st_q <= ST_IDLE;
          else if (conv_req_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: if (conv_res_valid) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [EVT_N-1:0]  evt_pulse,
  output logic              conv_req_valid,
  input  logic              conv_req_ready,
  output logic [1:0]        conv_src,
  output logic              conv_lowref,
  input  logic              conv_res_valid,
  output logic              conv_res_ready,
  input  logic [RES_W-1:0]  conv_res_data,
  output logic              irq
);
  logic [ENG_N-1:0]  en_w, done_w;
  logic              pd_w, aux_b_w, low_ref_w;
  logic [DATA_W-1:0] stat_w, mask_w;

  adc_seq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RES_W(RES_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .done_vec(done_w), .res_data(conv_res_data),
    .en_q(en_w), .pd_q(pd_w), .aux_b(aux_b_w), .low_ref(low_ref_w),
    .stat_q(stat_w), .mask_q(mask_w), .irq(irq)
  );

  adc_seq_arb u_arb (
    .clk(clk), .rst_n(rst_n), .en_q(en_w), .aux_b(aux_b_w), .low_ref(low_ref_w),
    .conv_req_valid(conv_req_valid), .conv_req_ready(conv_req_ready),
    .conv_src(conv_src), .conv_lowref(conv_lowref),
    .conv_res_valid(conv_res_valid), .conv_res_ready(conv_res_ready),
    .done_vec(done_w)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [3:0] evt_pulse,
  input logic       conv_req_valid,
  input logic       conv_req_ready,
  input logic       conv_res_ready,
  input logic [1:0] conv_src,
  input logic       irq,
  input logic [2:0] en_q,
  input logic       pd_q,
  input logic [7:0] stat_q,
  input logic [2:0] done_vec
);
  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_req_valid && conv_res_ready));

  p_src_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_valid && !conv_req_ready && !bus_wr) |=> (!conv_req_valid || $stable(conv_src)));

  p_done_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|done_vec) && !(bus_wr && bus_addr == 4'd0)) |=> ((en_q & $past(done_vec)) == 3'b000));

  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd3 && done_vec == 3'b000 && evt_pulse == 4'b0000)
      |=> ((stat_q & $past(bus_wdata)) == 8'h00));

  p_bit6_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[6] == 1'b0);

  p_mask_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd2 && bus_wdata == 8'hFF) |=> !irq);

  p_pd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |-> (!conv_req_valid && en_q == 3'b000));
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .evt_pulse(evt_pulse),
  .conv_req_valid(conv_req_valid), .conv_req_ready(conv_req_ready),
  .conv_res_ready(conv_res_ready), .conv_src(conv_src), .irq(irq),
  .en_q(en_w), .pd_q(pd_w), .stat_q(stat_w), .done_vec(done_w)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [3:0]  evt_pulse = '0;
  logic        conv_req_valid, conv_req_ready, conv_lowref, conv_res_ready, irq;
  logic [1:0]  conv_src;
  logic        conv_res_valid;
  logic [11:0] conv_res_data;

  adc_seq_ctrl u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // converter stand-in
  logic        allow_rdy = 1'b1;
  int          lat = 3;
  logic [11:0] stub_val = 12'h5A3;
  logic        s_busy;
  int          s_cnt;
  assign conv_req_ready = allow_rdy && !s_busy;

  always @(posedge clk) begin
    if (!rst_n) begin
      s_busy <= 1'b0; s_cnt <= 0; conv_res_valid <= 1'b0; conv_res_data <= '0;
    end else if (conv_req_valid && conv_req_ready) begin
      s_busy <= 1'b1; s_cnt <= lat; conv_res_data <= stub_val;
    end else if (s_busy && !conv_res_valid) begin
      if (s_cnt > 0) s_cnt <= s_cnt - 1;
      else conv_res_valid <= 1'b1;
    end else if (conv_res_valid && conv_res_ready) begin
      conv_res_valid <= 1'b0; s_busy <= 1'b0;
    end
  end

  // accepted request log
  logic [1:0] acc_q[$];
  always @(posedge clk) if (rst_n && conv_req_valid && conv_req_ready) acc_q.push_back(conv_src);

  // behavioural reference model
  logic [2:0]  m_en;
  logic        m_pd;
  logic [7:0]  m_cfg, m_mask, m_stat, m_rd;
  logic [11:0] m_aux, m_bat;
  int          ms, mc;

  function automatic logic [7:0] mread(logic [3:0] a);
    case (a)
      4'd0: return {m_pd, 4'b0, m_en};
      4'd1: return m_cfg;
      4'd2: return m_mask;
      4'd3: return m_stat;
      4'd4: return m_aux[7:0];
      4'd5: return {4'b0, m_aux[11:8]};
      4'd6: return m_bat[7:0];
      4'd7: return {4'b0, m_bat[11:8]};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin : mdl
    logic [2:0] dn;
    logic [7:0] nst;
    if (!rst_n) begin
      m_en = 0; m_pd = 0; m_cfg = 0; m_mask = 8'hFF; m_stat = 0; m_rd = 0;
      m_aux = 0; m_bat = 0; ms = 0; mc = 0;
    end else begin
      dn = 3'b000;
      if (ms == 2 && conv_res_valid && m_en[mc]) dn[mc] = 1'b1;
      if (bus_rd) m_rd = mread(bus_addr);
      case (ms)
        0: if (m_en != 0) begin mc = m_en[0] ? 0 : (m_en[1] ? 1 : 2); ms = 1; end
        1: if (!m_en[mc]) ms = 0; else if (conv_req_ready) ms = 2;
        default: if (conv_res_valid) ms = 0;
      endcase
      if (dn[0]) m_aux = conv_res_data;
      if (dn[1]) m_bat = conv_res_data;
      nst = m_stat;
      if (bus_wr && bus_addr == 4'd3) nst = nst & ~bus_wdata;
      nst = nst | {evt_pulse[3], 1'b0, evt_pulse[2], evt_pulse[1], evt_pulse[0], dn};
      m_stat = nst;
      if (bus_wr && bus_addr == 4'd0) begin
        m_pd = bus_wdata[7];
        m_en = bus_wdata[7] ? 3'b000 : bus_wdata[2:0];
      end else m_en = m_en & ~dn;
      if (bus_wr && bus_addr == 4'd1) m_cfg = bus_wdata;
      if (bus_wr && bus_addr == 4'd2) m_mask = bus_wdata;
    end
  end

  // per-cycle comparison after outputs settle
  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin : cmp
      logic reqv;
      logic [1:0] esrc;
      reqv = (ms == 1) && m_en[mc];
      esrc = (mc == 0) ? ((m_cfg[1:0] == 2'b10) ? 2'd1 : 2'd0) : ((mc == 1) ? 2'd2 : 2'd3);
      check("R3 conv_req_valid", conv_req_valid, reqv);
      if (reqv) begin
        check("R4 conv_src", conv_src, esrc);
        check("R4 conv_lowref", conv_lowref, (mc == 1) && m_cfg[4]);
      end
      check("R6 conv_res_ready", conv_res_ready, ms == 2);
      check("R9 irq", irq, |(m_stat & ~m_mask));
      check("R11 bus_rdata", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset values
    rd(4'd0, v); check("R1 enable", v, 8'h00);
    rd(4'd2, v); check("R1 mask", v, 8'hFF);
    rd(4'd3, v); check("R1 status", v, 8'h00);
    rd(4'd5, v); check("R1 aux high", v, 8'h00);
    check("R1 irq", irq, 1'b0);
    check("R1 req", conv_req_valid, 1'b0);

    // R2 / R5 aux conversion
    stub_val = 12'hABC;
    wr(4'd0, 8'h01);
    rd(4'd0, v); check("R2 busy bit", v, 8'h01);
    idle(20);
    rd(4'd0, v); check("R2 self clear", v, 8'h00);
    rd(4'd4, v); check("R5 aux low", v, 8'hBC);
    rd(4'd5, v); check("R5 aux high", v, 8'h0A);
    rd(4'd6, v); check("R5 bat untouched", v, 8'h00);
    rd(4'd3, v); check("R7 aux done", v, 8'h01);
    check("R9 masked", irq, 1'b0);

    // R9 / R8
    wr(4'd2, 8'hFE); check("R9 unmasked", irq, 1'b1);
    wr(4'd3, 8'h01);
    rd(4'd3, v); check("R8 cleared", v, 8'h00);
    check("R9 irq low", irq, 1'b0);

    // R4 second aux input and low reference
    wr(4'd1, 8'h12);
    stub_val = 12'h123;
    acc_q.delete();
    wr(4'd0, 8'h03);
    idle(40);
    check("R4 first src", acc_q.size() > 0 ? acc_q[0] : 2'bxx, 2'd1);
    rd(4'd6, v); check("R5 bat low", v, 8'h23);
    rd(4'd7, v); check("R5 bat high", v, 8'h01);

    // R3 priority
    wr(4'd3, 8'hFF);
    acc_q.delete();
    wr(4'd0, 8'h07);
    idle(60);
    check("R3 count", acc_q.size(), 3);
    if (acc_q.size() == 3) begin
      check("R3 order0", acc_q[0], 2'd1);
      check("R3 order1", acc_q[1], 2'd2);
      check("R3 order2", acc_q[2], 2'd3);
    end
    rd(4'd3, v); check("R3 all done", v, 8'h07);

    // R8 set beats clear, R7 events
    wr(4'd3, 8'hFF);
    @(negedge clk); evt_pulse = 4'b0001; bus_wr = 1'b1; bus_addr = 4'd3; bus_wdata = 8'h08;
    @(negedge clk); evt_pulse = 4'b0000; bus_wr = 1'b0;
    rd(4'd3, v); check("R8 set wins", v, 8'h08);
    @(negedge clk); evt_pulse = 4'b1110;
    @(negedge clk); evt_pulse = 4'b0000;
    rd(4'd3, v); check("R7 events", v, 8'hB8);
    wr(4'd3, 8'hFF);

    // R6 abort before acceptance
    allow_rdy = 1'b0;
    wr(4'd0, 8'h02);
    idle(5);
    check("R6 pending", conv_req_valid, 1'b1);
    wr(4'd0, 8'h00);
    check("R6 withdrawn", conv_req_valid, 1'b0);
    allow_rdy = 1'b1;
    idle(10);
    rd(4'd3, v); check("R6 no status", v, 8'h00);

    // R6 abort in flight
    lat = 20; stub_val = 12'h777;
    wr(4'd0, 8'h02);
    idle(4);
    wr(4'd0, 8'h00);
    idle(40);
    rd(4'd3, v); check("R6 inflight status", v, 8'h00);
    rd(4'd6, v); check("R6 result kept", v, 8'h23);

    // R10 power-down
    lat = 3;
    wr(4'd0, 8'h87);
    rd(4'd0, v); check("R10 pd read", v, 8'h80);
    idle(10);
    check("R10 no request", conv_req_valid, 1'b0);
    wr(4'd0, 8'h81);
    rd(4'd0, v); check("R10 start blocked", v, 8'h80);
    wr(4'd0, 8'h00);
    wr(4'd0, 8'h01);
    idle(20);
    rd(4'd3, v); check("R10 resumed", v, 8'h01);
    wr(4'd3, 8'hFF);
    lat = 20;
    wr(4'd0, 8'h01);
    idle(4);
    wr(4'd0, 8'h80);
    idle(40);
    rd(4'd3, v); check("R10 inflight dropped", v, 8'h00);
    wr(4'd0, 8'h00);

    // R11 hold
    rd(4'd1, v); check("R11 cfg read", v, 8'h12);
    idle(3);
    check("R11 hold", bus_rdata, 8'h12);

    idle(5);
    if (!finished) begin
      finished = 1;
      summary();
      $finish;
    end
  end
endmodule